// File: doc/BRIEF.md
# Shutdown and Wake-Up Controller

This block sequences the main supply of a chip from the always-on 32768 Hz slow-clock domain. Software cuts main power by writing a keyed command word to a small 32-bit register bus. The block then drives its active-low supply-enable output inactive and waits for a wake event. A wake event comes from an enabled external wake pin or from an enabled real-time-clock or periodic-timer alarm. Each wake pin has its own enable and polarity. All pins share one debounce length, chosen from a fixed set of slow-clock counts.

When a qualified wake event arrives while power is off, the block turns the supply back on. It also records which sources caused the wake in a status register. Software reads that register after boot, and the read clears it. An all-zero status therefore means a plain power-on. A shutdown command that arrives while a wake event is already qualified is dropped, so the system never powers down into a wake it would miss.

The bus uses word addresses: index 0 is the command register, 1 the mode register, 2 the status register and 3 the wake-input register. Reads return data combinationally, and writes take effect on the clock edge.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, supply_en_n is 0 (power on), and reads of the command, mode, status and wake-input registers all return 0.
- R2: Power is cut, with supply_en_n rising after the write edge, only by a command-register write whose bits 31:24 equal 0xA5 and whose bit 0 is 1. A wrong key, or a key with bit 0 clear, leaves supply_en_n at 0.
- R3: In the wake-input register, bit i (i in 0..15) enables pin i and bit 16+i sets its polarity: 1 means the pin is active when high, 0 means active when low. A disabled pin never wakes the block.
- R4: Mode bits 26:24 select the debounce count N: 0→0, 1→3, 2→32, 3→512, 4→4096, and 5, 6, 7→32768. Pins pass through a 2-stage synchronizer. A pin held active from just before slow-clock edge 1 wakes the block at edge N+3, and not before. A pin active for only N edges does not wake it.
- R5: Mode bit 17 enables the RTC alarm and mode bit 16 enables the RTT alarm. An enabled alarm that is high before an edge while power is off wakes the block at that edge. A disabled alarm has no effect.
- R6: On wake, supply_en_n returns to 0. At the same edge the status register takes bit 16+i for every qualified pin i, bit 5 if the RTC alarm woke it, and bit 4 if the RTT alarm woke it.
- R7: A status read returns the current status and clears it at that edge, so the next read returns 0. Wake events that occur while power is on set no status.
- R8: A valid shutdown command is ignored while any enabled wake source is already qualified, and supply_en_n stays 0.
- R9: With mode and wake-input registers written to 0, no pin or alarm activity restores power.
- R10: The mode register reads back only its implemented fields (bits 26:24, 17, 16). The wake-input register reads back all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 command, 1 mode, 2 status, 3 wake inputs |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| wake_pin | input | NUM_PINS | External wake pins, asynchronous |
| rtc_alarm | input | 1 | RTC alarm request, slow-clock synchronous |
| rtt_alarm | input | 1 | RTT alarm request, slow-clock synchronous |
| supply_en_n | output | 1 | Active-low main supply enable |

## Verification
Command effects appear on supply_en_n right after the write edge, so the bench samples at the falling edge that follows that write. A pin wake is due exactly N+3 edges after the pin changes: two edges for the synchronizer, N for the hold count, and one for the power register. Each pin test confirms that power is still off at edge N+2 and on at edge N+3. Alarms wake at the first edge. Status is read combinationally in the low half of the clock and cleared at the next edge, which a second read confirms.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int DATA_W     = 32;
  localparam int DBC_CNT_W  = 16;
  localparam int DBC_SEL_W  = 3;
  localparam logic [7:0] SHDN_KEY = 8'hA5;

  // word indices on the register bus
  localparam logic [1:0] IDX_CMD  = 2'd0;
  localparam logic [1:0] IDX_MODE = 2'd1;
  localparam logic [1:0] IDX_STAT = 2'd2;
  localparam logic [1:0] IDX_WIN  = 2'd3;

  // field positions
  localparam int MODE_DBC_LSB = 24;
  localparam int MODE_RTC_BIT = 17;
  localparam int MODE_RTT_BIT = 16;
  localparam int STAT_RTC_BIT = 5;
  localparam int STAT_RTT_BIT = 4;
  localparam int STAT_PIN_LSB = 16;
  localparam int WIN_POL_LSB  = 16;

  // debounce hold count for a selector value
  function automatic logic [DBC_CNT_W-1:0] dbc_limit(input logic [DBC_SEL_W-1:0] sel);
    logic [DBC_CNT_W-1:0] lim;
    case (sel)
      3'd0:    lim = 16'd0;
      3'd1:    lim = 16'd3;
      3'd2:    lim = 16'd32;
      3'd3:    lim = 16'd512;
      3'd4:    lim = 16'd4096;
      default: lim = 16'd32768;
    endcase
    return lim;
  endfunction

  // a shutdown word is valid when key matches and the command bit is set
  function automatic logic cmd_is_shutdown(input logic [DATA_W-1:0] w);
    return (w[31:24] == SHDN_KEY) && w[0];
  endfunction
endpackage

// File: rtl/pwr_wake_debounce.sv
module pwr_wake_debounce
  import pwr_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_raw,
  input  logic                 enable,
  input  logic                 polarity,
  input  logic [DBC_CNT_W-1:0] limit,
  output logic                 active_o,
  output logic                 qual_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [DBC_CNT_W-1:0]   hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
  end

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign active_o = enable && (pin_s == polarity);

  // counts consecutive active cycles already seen, saturating at limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hold_cnt <= '0;
    else if (!active_o)       hold_cnt <= '0;
    else if (hold_cnt < limit) hold_cnt <= hold_cnt + 1'b1;
  end

  assign qual_o = active_o && (hold_cnt >= limit);

  // R4: a qualified event with nonzero hold count needs a prior active cycle
  assert_hold_before_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && limit != '0) |-> $past(active_o));
endmodule

// File: rtl/pwr_wake_regs.sv
module pwr_wake_regs
  import pwr_wake_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [DATA_W-1:0]    status_i,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [DBC_SEL_W-1:0] dbc_sel,
  output logic                 rtc_en,
  output logic                 rtt_en,
  output logic [NUM_PINS-1:0]  pin_en,
  output logic [NUM_PINS-1:0]  pin_pol,
  output logic                 shdn_req,
  output logic                 stat_rd
);
  logic wr_mode, wr_win;

  assign wr_mode  = bus_sel && bus_wr && (bus_addr == IDX_MODE);
  assign wr_win   = bus_sel && bus_wr && (bus_addr == IDX_WIN);
  assign shdn_req = bus_sel && bus_wr && (bus_addr == IDX_CMD) && cmd_is_shutdown(bus_wdata);
  assign stat_rd  = bus_sel && !bus_wr && (bus_addr == IDX_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbc_sel <= '0;
      rtc_en  <= 1'b0;
      rtt_en  <= 1'b0;
    end else if (wr_mode) begin
      dbc_sel <= bus_wdata[MODE_DBC_LSB +: DBC_SEL_W];
      rtc_en  <= bus_wdata[MODE_RTC_BIT];
      rtt_en  <= bus_wdata[MODE_RTT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en  <= '0;
      pin_pol <= '0;
    end else if (wr_win) begin
      pin_en  <= bus_wdata[NUM_PINS-1:0];
      pin_pol <= bus_wdata[WIN_POL_LSB +: NUM_PINS];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_MODE: begin
        bus_rdata[MODE_DBC_LSB +: DBC_SEL_W] = dbc_sel;
        bus_rdata[MODE_RTC_BIT]              = rtc_en;
        bus_rdata[MODE_RTT_BIT]              = rtt_en;
      end
      IDX_STAT: bus_rdata = status_i;
      IDX_WIN: begin
        bus_rdata[NUM_PINS-1:0]            = pin_en;
        bus_rdata[WIN_POL_LSB +: NUM_PINS] = pin_pol;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import pwr_wake_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shdn_req,
  input  logic                stat_rd,
  input  logic [NUM_PINS-1:0] pin_qual,
  input  logic                rtc_wake,
  input  logic                rtt_wake,
  output logic [DATA_W-1:0]   status_o,
  output logic                supply_en_n
);
  logic              powered;
  logic              pending;
  logic              wake_now;
  logic [DATA_W-1:0] wake_vec;

  assign pending  = (|pin_qual) || rtc_wake || rtt_wake;
  assign wake_now = !powered && pending;

  always_comb begin
    wake_vec = '0;
    wake_vec[STAT_PIN_LSB +: NUM_PINS] = pin_qual;
    wake_vec[STAT_RTC_BIT]             = rtc_wake;
    wake_vec[STAT_RTT_BIT]             = rtt_wake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      powered <= 1'b1;
    else if (powered)                powered <= !(shdn_req && !pending);
    else if (pending)                powered <= 1'b1;
  end

  // a wake capture wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_o <= '0;
    else if (wake_now) status_o <= status_o | wake_vec;
    else if (stat_rd)  status_o <= '0;
  end

  assign supply_en_n = !powered;

  assert_wake_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en_n) |-> (status_o != '0));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wake_now) |=> (status_o == '0));

  assert_pending_blocks_shdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_req && pending && powered) |=> !supply_en_n);

  assert_idle_stays_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_en_n && !pending) |=> supply_en_n);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] wake_pin,
  input  logic                rtc_alarm,
  input  logic                rtt_alarm,
  output logic                supply_en_n
);
  logic [DBC_SEL_W-1:0] dbc_sel;
  logic [DBC_CNT_W-1:0] dbc_lim;
  logic                 rtc_en, rtt_en;
  logic [NUM_PINS-1:0]  pin_en, pin_pol, pin_act, pin_qual;
  logic                 shdn_req, stat_rd;
  logic [DATA_W-1:0]    status;
  logic                 rtc_wake, rtt_wake;

  pwr_wake_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status_i(status), .bus_rdata(bus_rdata),
    .dbc_sel(dbc_sel), .rtc_en(rtc_en), .rtt_en(rtt_en),
    .pin_en(pin_en), .pin_pol(pin_pol),
    .shdn_req(shdn_req), .stat_rd(stat_rd)
  );

  assign dbc_lim = dbc_limit(dbc_sel);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pwr_wake_debounce #(.SYNC_STAGES(SYNC_STAGES)) u_dbc (
      .clk(clk), .rst_n(rst_n),
      .pin_raw(wake_pin[i]), .enable(pin_en[i]), .polarity(pin_pol[i]),
      .limit(dbc_lim), .active_o(pin_act[i]), .qual_o(pin_qual[i])
    );
  end

  assign rtc_wake = rtc_en && rtc_alarm;
  assign rtt_wake = rtt_en && rtt_alarm;

  pwr_wake_seq #(.NUM_PINS(NUM_PINS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .shdn_req(shdn_req), .stat_rd(stat_rd),
    .pin_qual(pin_qual), .rtc_wake(rtc_wake), .rtt_wake(rtt_wake),
    .status_o(status), .supply_en_n(supply_en_n)
  );

  // R2: a command write with a wrong key keeps power on
  assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == IDX_CMD && bus_wdata[31:24] != SHDN_KEY && !supply_en_n)
    |=> !supply_en_n);

  // R5: an enabled RTC alarm while off restores power at once
  assert_rtc_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_en_n && rtc_en && rtc_alarm) |=> !supply_en_n);

  // R3: a pin counted as active must be enabled
  assert_active_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pin_act & ~pin_en)) == 1'b0);
endmodule

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
  localparam int CLK_P = 10;
  localparam int SYNC  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] wake_pin = '0;
  logic        rtc_alarm = 1'b0, rtt_alarm = 1'b0;
  logic        supply_en_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwr_wake_ctrl i_pwr_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm),
    .supply_en_n(supply_en_n)
  );

  function automatic int exp_limit(int sel);
    if (sel == 0) return 0;
    if (sel == 1) return 3;
    if (sel == 2) return 32;
    if (sel == 3) return 512;
    if (sel == 4) return 4096;
    return 32768;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wake_pin = '0; rtc_alarm = 1'b0; rtt_alarm = 1'b0; bus_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic test_reset_r1();
    logic [31:0] d;
    do_reset();
    chk("R1 supply", {31'b0, supply_en_n}, 32'h0);
    rd(2'd0, d); chk("R1 cmd", d, 32'h0);
    rd(2'd1, d); chk("R1 mode", d, 32'h0);
    rd(2'd2, d); chk("R1 status", d, 32'h0);
    rd(2'd3, d); chk("R1 win", d, 32'h0);
  endtask

  task automatic test_readback_r10();
    logic [31:0] d;
    do_reset();
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 mode fields", d, 32'h0703_0000);
    wr(2'd3, 32'h1234_ABCD);
    rd(2'd3, d); chk("R10 win", d, 32'h1234_ABCD);
  endtask

  task automatic test_key_r2();
    do_reset();
    wr(2'd0, 32'hA400_0001);
    chk("R2 wrong key", {31'b0, supply_en_n}, 32'h0);
    wr(2'd0, 32'hA500_0000);
    chk("R2 bit0 clear", {31'b0, supply_en_n}, 32'h0);
    wr(2'd1, 32'hA500_0001);
    chk("R2 wrong register", {31'b0, supply_en_n}, 32'h0);
    wr(2'd0, 32'hA500_0001);
    chk("R2 valid shutdown", {31'b0, supply_en_n}, 32'h1);
  endtask

  // pin 0 active high with selector sel; checks the wake edge and status
  task automatic test_pin_dbc_r4(int sel);
    logic [31:0] d;
    int n;
    n = exp_limit(sel);
    do_reset();
    wr(2'd1, sel << 24);
    wr(2'd3, 32'h0001_0001);
    wr(2'd0, 32'hA500_0001);
    wake_pin[0] = 1'b1;
    repeat (SYNC + n) @(posedge clk);
    @(negedge clk);
    chk($sformatf("R4 still off sel %0d", sel), {31'b0, supply_en_n}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    chk($sformatf("R4 wake edge sel %0d", sel), {31'b0, supply_en_n}, 32'h0);
    rd(2'd2, d); chk("R6 pin0 status", d, 32'h0001_0000);
    rd(2'd2, d); chk("R7 cleared", d, 32'h0);
  endtask

  task automatic test_short_pulse_r4();
    do_reset();
    wr(2'd1, 32'h0100_0000);
    wr(2'd3, 32'h0001_0001);
    wr(2'd0, 32'hA500_0001);
    wake_pin[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wake_pin[0] = 1'b0;
    repeat (10) @(negedge clk);
    chk("R4 short pulse ignored", {31'b0, supply_en_n}, 32'h1);
  endtask

  task automatic test_polarity_r3();
    logic [31:0] d;
    do_reset();
    wake_pin[2] = 1'b1;
    // pin2 enabled active low, pin9 enabled active high, pin5 disabled
    wr(2'd3, 32'h0200_0204);
    wr(2'd0, 32'hA500_0001);
    wake_pin[5] = 1'b1;
    wake_pin[2] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 disabled pin", {31'b0, supply_en_n}, 32'h1);
    wake_pin[2] = 1'b0;
    wake_pin[9] = 1'b1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    chk("R3 before wake", {31'b0, supply_en_n}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    chk("R3 polarity wake", {31'b0, supply_en_n}, 32'h0);
    rd(2'd2, d); chk("R6 two pins", d, 32'h0204_0000);
  endtask

  task automatic test_alarms_r5();
    logic [31:0] d;
    do_reset();
    wr(2'd1, 32'h0002_0000);
    wr(2'd0, 32'hA500_0001);
    rtt_alarm = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 rtt disabled", {31'b0, supply_en_n}, 32'h1);
    rtt_alarm = 1'b0;
    rtc_alarm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rtc_alarm = 1'b0;
    chk("R5 rtc wake", {31'b0, supply_en_n}, 32'h0);
    rd(2'd2, d); chk("R6 rtc status", d, 32'h0000_0020);
    wr(2'd1, 32'h0001_0000);
    wr(2'd0, 32'hA500_0001);
    rtt_alarm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rtt_alarm = 1'b0;
    chk("R5 rtt wake", {31'b0, supply_en_n}, 32'h0);
    rd(2'd2, d); chk("R6 rtt status", d, 32'h0000_0010);
  endtask

  task automatic test_pending_r8();
    logic [31:0] d;
    do_reset();
    wr(2'd3, 32'h0001_0001);
    wake_pin[0] = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 32'hA500_0001);
    chk("R8 pin pending", {31'b0, supply_en_n}, 32'h0);
    wake_pin[0] = 1'b0;
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h0002_0000);
    rtc_alarm = 1'b1;
    wr(2'd0, 32'hA500_0001);
    rtc_alarm = 1'b0;
    chk("R8 rtc pending", {31'b0, supply_en_n}, 32'h0);
    rd(2'd2, d); chk("R7 no status while on", d, 32'h0);
  endtask

  task automatic test_disable_r9();
    do_reset();
    wr(2'd1, 32'h0003_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'hA500_0001);
    wake_pin = 16'hFFFF; rtc_alarm = 1'b1; rtt_alarm = 1'b1;
    repeat (5) @(negedge clk);
    wake_pin = 16'h0;
    repeat (5) @(negedge clk);
    chk("R9 all disabled", {31'b0, supply_en_n}, 32'h1);
  endtask

  initial begin
    test_reset_r1();
    test_readback_r10();
    test_key_r2();
    test_pin_dbc_r4(0);
    test_pin_dbc_r4(1);
    test_pin_dbc_r4(3);
    test_pin_dbc_r4(5);
    test_short_pulse_r4();
    test_polarity_r3();
    test_alarms_r5();
    test_pending_r8();
    test_disable_r9();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule